// File: doc/BRIEF.md
# Paravirtual Device Register Front-End

This block is the register window of a legacy paravirtual I/O device attached over PCI. A host-side access port issues byte, halfword or word reads and writes at byte offsets inside the window. The block decodes the fixed common header: feature masks, queue selection, per-queue page frames and interrupt vectors, device status and the interrupt status byte. It also carries out the side effects of each access: queue-notify strobes, device reset, and read-to-clear of the interrupt status. Offsets past the header are passed straight through to a device-specific configuration port. The header is 20 bytes long with message-signalled interrupts off and 24 bytes long with them on.

Device events come in on two strobes, one for a queue and one for a configuration change. In legacy mode they raise a level interrupt through the interrupt status byte. With message interrupts on, they emit a one-cycle message request that carries the programmed vector.

Top module: `pvr_front`

## Requirements
- R1: A read at offset 0 returns the HOST_FEAT parameter OR'd with bits 24, 28 and 30 forced to 1. Bit 30 is the bad-negotiation marker.
- R2: Offset 4 holds the guest feature word and reads it back. A write with bit 30 set stores 0 in place of the written value. The stored word is driven on guest_feat_o.
- R3: Offset 14 is the queue select and reads back zero-extended. A write whose low 16 bits are not below NQ leaves the selection unchanged.
- R4: Offset 8 reads and writes the page frame of the selected queue. sel_qbase_o equals that frame shifted left by 12. Offset 12 reads QUEUE_SIZE.
- R5: A write to offset 16 drives notify_o high for exactly one cycle, in the cycle after the write, with notify_qidx_o equal to the low 16 bits written.
- R6: A write of 0 to offset 8, or a write to offset 18 whose low byte is 0, triggers a device reset. The reset clears guest features, status, interrupt status, queue select and every page frame, and sets every vector to 0xFFFF. dev_reset_o is high for the single cycle after the write. Any other write to offset 18 stores the low byte as the status, which reads back there and appears on status_o.
- R7: Offset 19 reads the interrupt status. A queue event sets bit 0, and a configuration event sets bits 0 and 1. A read returns the current value and clears it. An event in the same cycle as the read is kept.
- R8: With message interrupts off, irq_o equals bit 0 of the interrupt status. With them on, irq_o is 0.
- R9: With message interrupts on, offset 20 is the configuration vector and offset 22 is the vector of the selected queue. A written value below NV is stored, and any other value stores 0xFFFF. After reset both read 0xFFFF.
- R10: With message interrupts on, an event whose vector is not 0xFFFF drives msg_valid_o for one cycle, in the cycle after the event, with msg_vector_o equal to that vector. An event whose vector is 0xFFFF sends nothing. A queue event takes priority over a configuration event in the same cycle.
- R11: Offsets at or past the header length (20, or 24 with message interrupts on) raise dcfg_req_o. The offset is passed with the header length subtracted, write data and direction pass through, and a read returns dcfg_rdata_i.
- R12: Header offsets that hold no register read as 0xFFFFFFFF, and writes to them change nothing. The notify offset also reads as 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msix_en_i | input | 1 | Message-signalled interrupts enabled |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| addr_i | input | AW | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| dcfg_req_o | output | 1 | Device-config access strobe |
| dcfg_we_o | output | 1 | Device-config write |
| dcfg_size_o | output | 2 | Device-config access size |
| dcfg_addr_o | output | AW | Offset inside device config |
| dcfg_wdata_o | output | 32 | Device-config write data |
| dcfg_rdata_i | input | 32 | Device-config read data |
| evt_queue_i | input | 1 | Queue event strobe |
| evt_qidx_i | input | SELW | Queue of the event |
| evt_cfg_i | input | 1 | Configuration-change strobe |
| notify_o | output | 1 | Queue-notify pulse |
| notify_qidx_o | output | 16 | Notified queue index |
| irq_o | output | 1 | Legacy level interrupt |
| msg_valid_o | output | 1 | Message interrupt request |
| msg_vector_o | output | 16 | Vector of the request |
| dev_reset_o | output | 1 | Device back-end reset pulse |
| guest_feat_o | output | 32 | Accepted guest features |
| status_o | output | 8 | Device status |
| sel_qbase_o | output | 44 | Base address of the selected queue |

## Verification
The bench goes after the writes that reset the device: a zero page frame and a zero status byte. A design that treated either one as an ordinary store would keep stale frames and features, and it would never pulse dev_reset_o. The bench also races an event against a read of the interrupt status in the same cycle; a design that let the clear win would lose the interrupt. A random run with message interrupts on and then off moves the header boundary, so an off-by-four decode shows up as misrouted device-config accesses. Out-of-range selects and vectors are written often; a design without range checks would move the selection, or would store a vector where 0xFFFF belongs.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
  localparam int unsigned OFF_HOST_FEAT  = 0;
  localparam int unsigned OFF_GUEST_FEAT = 4;
  localparam int unsigned OFF_PFN        = 8;
  localparam int unsigned OFF_QSIZE      = 12;
  localparam int unsigned OFF_QSEL       = 14;
  localparam int unsigned OFF_NOTIFY     = 16;
  localparam int unsigned OFF_STATUS     = 18;
  localparam int unsigned OFF_ISR        = 19;
  localparam int unsigned OFF_CFG_VEC    = 20;
  localparam int unsigned OFF_Q_VEC      = 22;
  localparam int unsigned HDR_LEGACY     = 20;
  localparam int unsigned HDR_MSG        = 24;
  localparam int unsigned PAGE_SHIFT     = 12;
  localparam int unsigned BAD_FEAT_BIT   = 30;
  localparam logic [15:0] NO_VEC         = 16'hFFFF;
  localparam logic [31:0] FIXED_FEAT     = 32'h5100_0000; // bits 24, 28, 30

  typedef enum logic [3:0] {
    RG_NONE, RG_HOST_FEAT, RG_GUEST_FEAT, RG_PFN, RG_QSIZE, RG_QSEL,
    RG_NOTIFY, RG_STATUS, RG_ISR, RG_CFG_VEC, RG_Q_VEC, RG_DEV
  } reg_e;
endpackage

// File: rtl/pvr_decode.sv
module pvr_decode
  import pvr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic          msix_en_i,
  output reg_e          reg_o,
  output logic [AW-1:0] dev_addr_o
);
  localparam logic [AW-1:0] HdrS = AW'(HDR_LEGACY);
  localparam logic [AW-1:0] HdrL = AW'(HDR_MSG);

  logic [AW-1:0] hdr_len;

  always_comb begin
    hdr_len    = msix_en_i ? HdrL : HdrS;
    dev_addr_o = addr_i - hdr_len;
    reg_o      = RG_NONE;
    if (addr_i >= hdr_len) begin
      reg_o = RG_DEV;
    end else begin
      case (addr_i)
        AW'(OFF_HOST_FEAT):  reg_o = RG_HOST_FEAT;
        AW'(OFF_GUEST_FEAT): reg_o = RG_GUEST_FEAT;
        AW'(OFF_PFN):        reg_o = RG_PFN;
        AW'(OFF_QSIZE):      reg_o = RG_QSIZE;
        AW'(OFF_QSEL):       reg_o = RG_QSEL;
        AW'(OFF_NOTIFY):     reg_o = RG_NOTIFY;
        AW'(OFF_STATUS):     reg_o = RG_STATUS;
        AW'(OFF_ISR):        reg_o = RG_ISR;
        AW'(OFF_CFG_VEC):    reg_o = RG_CFG_VEC;
        AW'(OFF_Q_VEC):      reg_o = RG_Q_VEC;
        default:             reg_o = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pvr_queue_tbl.sv
module pvr_queue_tbl
  import pvr_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int NV   = 8,
  parameter int SELW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            pfn_we_i,
  input  logic [31:0]     pfn_i,
  input  logic            vec_we_i,
  input  logic [15:0]     vec_i,
  input  logic [SELW-1:0] evt_idx_i,
  output logic [31:0]     sel_pfn_o,
  output logic [15:0]     sel_vec_o,
  output logic [15:0]     evt_vec_o
);
  logic [NQ-1:0][31:0] pfn_all;
  logic [NQ-1:0][15:0] vec_all;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [31:0] pfn_r;
    logic [15:0] vec_r;
    logic        hit;
    assign hit = (sel_i == SELW'(q));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pfn_r <= '0;
        vec_r <= NO_VEC;
      end else if (clr_i) begin
        pfn_r <= '0;
        vec_r <= NO_VEC;
      end else begin
        if (pfn_we_i && hit) pfn_r <= pfn_i;
        if (vec_we_i && hit) vec_r <= vec_i;
      end
    end
    assign pfn_all[q] = pfn_r;
    assign vec_all[q] = vec_r;
  end

  assign sel_pfn_o = pfn_all[sel_i];
  assign sel_vec_o = vec_all[sel_i];
  assign evt_vec_o = (32'(evt_idx_i) < NQ) ? vec_all[evt_idx_i] : NO_VEC;

  p_vec_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_vec_o == NO_VEC) || (32'(sel_vec_o) < NV));
endmodule

// File: rtl/pvr_irq.sv
module pvr_irq
  import pvr_pkg::*;
#(
  parameter int NV = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        msix_en_i,
  input  logic        evt_queue_i,
  input  logic        evt_cfg_i,
  input  logic [15:0] qvec_i,
  input  logic [15:0] cfgvec_i,
  input  logic        isr_rd_i,
  output logic [7:0]  isr_o,
  output logic        irq_o,
  output logic        msg_valid_o,
  output logic [15:0] msg_vector_o
);
  logic [7:0]  isr_q;
  logic [7:0]  isr_set;
  logic        msg_q;
  logic [15:0] vec_q;

  assign isr_set = {6'b0, evt_cfg_i, evt_queue_i | evt_cfg_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      msg_q <= 1'b0;
      vec_q <= NO_VEC;
    end else begin
      // an event arriving with the read-clear survives it
      if (clr_i) isr_q <= '0;
      else       isr_q <= (isr_rd_i ? 8'h00 : isr_q) | isr_set;
      msg_q <= 1'b0;
      if (msix_en_i && evt_queue_i) begin
        msg_q <= (qvec_i != NO_VEC);
        vec_q <= qvec_i;
      end else if (msix_en_i && evt_cfg_i) begin
        msg_q <= (cfgvec_i != NO_VEC);
        vec_q <= cfgvec_i;
      end
    end
  end

  assign isr_o        = isr_q;
  assign irq_o        = !msix_en_i && isr_q[0];
  assign msg_valid_o  = msg_q;
  assign msg_vector_o = vec_q;

  p_isr_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_rd_i && !evt_queue_i && !evt_cfg_i) |=> (isr_o == 8'h00));
  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_queue_i && !clr_i && !msix_en_i) |=> (irq_o || msix_en_i));
  p_msg_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (32'(msg_vector_o) < NV));
endmodule

// File: rtl/pvr_front.sv
module pvr_front
  import pvr_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          NQ         = 4,
  parameter int          NV         = 8,
  parameter int          QUEUE_SIZE = 256,
  parameter logic [31:0] HOST_FEAT  = 32'h0000_0021,
  localparam int         SELW       = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int         QBW        = 32 + PAGE_SHIFT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            msix_en_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [1:0]      size_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            dcfg_req_o,
  output logic            dcfg_we_o,
  output logic [1:0]      dcfg_size_o,
  output logic [AW-1:0]   dcfg_addr_o,
  output logic [31:0]     dcfg_wdata_o,
  input  logic [31:0]     dcfg_rdata_i,
  input  logic            evt_queue_i,
  input  logic [SELW-1:0] evt_qidx_i,
  input  logic            evt_cfg_i,
  output logic            notify_o,
  output logic [15:0]     notify_qidx_o,
  output logic            irq_o,
  output logic            msg_valid_o,
  output logic [15:0]     msg_vector_o,
  output logic            dev_reset_o,
  output logic [31:0]     guest_feat_o,
  output logic [7:0]      status_o,
  output logic [QBW-1:0]  sel_qbase_o
);
  reg_e            rsel;
  logic [AW-1:0]   dev_addr;
  logic            wr, rd, soft_rst;
  logic [15:0]     vec_val;
  logic [31:0]     guest_feat_q;
  logic [7:0]      status_q;
  logic [SELW-1:0] sel_q;
  logic [15:0]     cfg_vec_q;
  logic            notify_q, rst_pulse_q;
  logic [15:0]     notify_idx_q;
  logic [31:0]     sel_pfn;
  logic [15:0]     sel_vec, evt_vec;
  logic [7:0]      isr;

  pvr_decode #(.AW(AW)) u_dec (
    .addr_i(addr_i), .msix_en_i(msix_en_i), .reg_o(rsel), .dev_addr_o(dev_addr)
  );

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign soft_rst = wr && (((rsel == RG_PFN) && (wdata_i == 32'h0)) ||
                           ((rsel == RG_STATUS) && (wdata_i[7:0] == 8'h00)));
  assign vec_val  = (32'(wdata_i[15:0]) < NV) ? wdata_i[15:0] : NO_VEC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guest_feat_q <= '0;
      status_q     <= '0;
      sel_q        <= '0;
      cfg_vec_q    <= NO_VEC;
      notify_q     <= 1'b0;
      notify_idx_q <= '0;
      rst_pulse_q  <= 1'b0;
    end else begin
      notify_q    <= wr && (rsel == RG_NOTIFY);
      rst_pulse_q <= soft_rst;
      if (wr && (rsel == RG_NOTIFY)) notify_idx_q <= wdata_i[15:0];
      if (soft_rst) begin
        guest_feat_q <= '0;
        status_q     <= '0;
        sel_q        <= '0;
        cfg_vec_q    <= NO_VEC;
      end else if (wr) begin
        case (rsel)
          RG_GUEST_FEAT: guest_feat_q <= wdata_i[BAD_FEAT_BIT] ? 32'h0 : wdata_i;
          RG_QSEL:       if (32'(wdata_i[15:0]) < NQ) sel_q <= wdata_i[SELW-1:0];
          RG_STATUS:     status_q <= wdata_i[7:0];
          RG_CFG_VEC:    cfg_vec_q <= vec_val;
          default: ;
        endcase
      end
    end
  end

  pvr_queue_tbl #(.NQ(NQ), .NV(NV), .SELW(SELW)) u_qtbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(soft_rst), .sel_i(sel_q),
    .pfn_we_i(wr && (rsel == RG_PFN) && !soft_rst), .pfn_i(wdata_i),
    .vec_we_i(wr && (rsel == RG_Q_VEC)), .vec_i(vec_val),
    .evt_idx_i(evt_qidx_i), .sel_pfn_o(sel_pfn), .sel_vec_o(sel_vec),
    .evt_vec_o(evt_vec)
  );

  pvr_irq #(.NV(NV)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(soft_rst), .msix_en_i(msix_en_i),
    .evt_queue_i(evt_queue_i), .evt_cfg_i(evt_cfg_i), .qvec_i(evt_vec),
    .cfgvec_i(cfg_vec_q), .isr_rd_i(rd && (rsel == RG_ISR)), .isr_o(isr),
    .irq_o(irq_o), .msg_valid_o(msg_valid_o), .msg_vector_o(msg_vector_o)
  );

  always_comb begin
    case (rsel)
      RG_HOST_FEAT:  rdata_o = HOST_FEAT | FIXED_FEAT;
      RG_GUEST_FEAT: rdata_o = guest_feat_q;
      RG_PFN:        rdata_o = sel_pfn;
      RG_QSIZE:      rdata_o = 32'(16'(QUEUE_SIZE));
      RG_QSEL:       rdata_o = 32'(sel_q);
      RG_STATUS:     rdata_o = 32'(status_q);
      RG_ISR:        rdata_o = 32'(isr);
      RG_CFG_VEC:    rdata_o = 32'(cfg_vec_q);
      RG_Q_VEC:      rdata_o = 32'(sel_vec);
      RG_DEV:        rdata_o = dcfg_rdata_i;
      default:       rdata_o = 32'hFFFF_FFFF;
    endcase
  end

  assign dcfg_req_o    = req_i && (rsel == RG_DEV);
  assign dcfg_we_o     = we_i;
  assign dcfg_size_o   = size_i;
  assign dcfg_addr_o   = dev_addr;
  assign dcfg_wdata_o  = wdata_i;
  assign notify_o      = notify_q;
  assign notify_qidx_o = notify_idx_q;
  assign dev_reset_o   = rst_pulse_q;
  assign guest_feat_o  = guest_feat_q;
  assign status_o      = status_q;
  assign sel_qbase_o   = {sel_pfn, {PAGE_SHIFT{1'b0}}};

  p_reset_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_reset_o |-> (guest_feat_o == 32'h0 && status_o == 8'h0 && sel_q == '0));
  p_notify_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> $past(req_i && we_i && rsel == RG_NOTIFY));
  p_sel_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sel_q) < NQ);
  p_dev_fwd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (32'(addr_i) >= (msix_en_i ? HDR_MSG : HDR_LEGACY))) |-> dcfg_req_o);
endmodule

// File: tb/pvr_front_tb_top.sv
`timescale 1ns/1ps
module pvr_front_tb_top;
  localparam int NQ = 4, NV = 8, QS = 256, AW = 8, SELW = 2;
  localparam logic [31:0] HF = 32'h0000_0021;
  localparam logic [31:0] DCFG = 32'hC0DE_5A17;

  logic clk = 1'b0, rst_n = 1'b0, msix_en = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] size = 2'd2;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic dcfg_req, dcfg_we;
  logic [1:0] dcfg_size;
  logic [AW-1:0] dcfg_addr;
  logic [31:0] dcfg_wdata;
  logic [31:0] dcfg_rdata = DCFG;
  logic evt_q = 1'b0, evt_c = 1'b0;
  logic [SELW-1:0] evt_idx = '0;
  logic notify, irq, msg_valid, dev_reset;
  logic [15:0] notify_qidx, msg_vector;
  logic [31:0] guest_feat;
  logic [7:0] status;
  logic [43:0] sel_qbase;

  always #2 clk = ~clk;

  pvr_front #(.AW(AW), .NQ(NQ), .NV(NV), .QUEUE_SIZE(QS), .HOST_FEAT(HF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .msix_en_i(msix_en), .req_i(req), .we_i(we),
    .size_i(size), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .dcfg_req_o(dcfg_req), .dcfg_we_o(dcfg_we), .dcfg_size_o(dcfg_size),
    .dcfg_addr_o(dcfg_addr), .dcfg_wdata_o(dcfg_wdata), .dcfg_rdata_i(dcfg_rdata),
    .evt_queue_i(evt_q), .evt_qidx_i(evt_idx), .evt_cfg_i(evt_c),
    .notify_o(notify), .notify_qidx_o(notify_qidx), .irq_o(irq),
    .msg_valid_o(msg_valid), .msg_vector_o(msg_vector), .dev_reset_o(dev_reset),
    .guest_feat_o(guest_feat), .status_o(status), .sel_qbase_o(sel_qbase)
  );

  int total = 0, bad = 0;
  bit msix_m;
  logic [31:0] gf_m;
  logic [7:0] st_m, isr_m;
  int sel_m;
  logic [31:0] pfn_m [NQ];
  logic [15:0] qv_m [NQ];
  logic [15:0] cfgv_m;

  function automatic void m_reset();
    gf_m = '0; st_m = '0; isr_m = '0; sel_m = 0; cfgv_m = 16'hFFFF;
    for (int i = 0; i < NQ; i++) begin pfn_m[i] = '0; qv_m[i] = 16'hFFFF; end
  endfunction

  function automatic int hdr();
    return msix_m ? 24 : 20;
  endfunction

  function automatic logic [15:0] vchk(logic [15:0] v);
    return (int'(v) < NV) ? v : 16'hFFFF;
  endfunction

  function automatic bit m_write(int a, logic [31:0] d);
    if (a >= hdr()) return 1'b0;
    case (a)
      4:  gf_m = d[30] ? 32'h0 : d;
      8:  if (d == 0) begin m_reset(); return 1'b1; end else pfn_m[sel_m] = d;
      14: if (int'(d[15:0]) < NQ) sel_m = int'(d[15:0]);
      18: if (d[7:0] == 0) begin m_reset(); return 1'b1; end else st_m = d[7:0];
      20: cfgv_m = vchk(d[15:0]);
      22: qv_m[sel_m] = vchk(d[15:0]);
      default: ;
    endcase
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    if (a >= hdr()) return DCFG;
    case (a)
      0:  return HF | 32'h5100_0000;
      4:  return gf_m;
      8:  return pfn_m[sel_m];
      12: return 32'(QS);
      14: return 32'(sel_m);
      18: return 32'(st_m);
      19: return 32'(isr_m);
      20: return 32'(cfgv_m);
      22: return 32'(qv_m[sel_m]);
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bit rst_e;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    #1;
    if (a >= hdr())
      chk(dcfg_req && dcfg_we && dcfg_addr == AW'(a - hdr()) && dcfg_wdata == d, "R11",
          {dcfg_req, dcfg_addr}, {1'b1, 8'(a - hdr())});
    rst_e = m_write(a, d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk(dev_reset == rst_e, "R6 reset pulse", 64'(dev_reset), 64'(rst_e));
    if (a == 16)
      chk(notify && notify_qidx == d[15:0], "R5", {notify, notify_qidx}, {1'b1, d[15:0]});
    else
      chk(!notify, "R5 no notify", 64'(notify), 0);
  endtask

  task automatic rd(input int a, input string rq);
    logic [31:0] e;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    #1;
    e = exp_rd(a);
    chk(rdata == e, rq, 64'(rdata), 64'(e));
    if (a >= hdr())
      chk(dcfg_req && !dcfg_we && dcfg_addr == AW'(a - hdr()), "R11 read fwd",
          64'(dcfg_addr), 64'(a - hdr()));
    if (a == 19) isr_m = '0;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic evt(input bit isq, input int idx);
    bit mv;
    logic [15:0] ev;
    @(negedge clk);
    evt_q = isq; evt_c = !isq; evt_idx = SELW'(idx);
    ev = isq ? qv_m[idx] : cfgv_m;
    mv = msix_m && (ev != 16'hFFFF);
    isr_m = isr_m | (isq ? 8'h01 : 8'h03);
    @(negedge clk);
    evt_q = 1'b0; evt_c = 1'b0;
    chk(msg_valid == mv, "R10 msg valid", 64'(msg_valid), 64'(mv));
    if (mv) chk(msg_vector == ev, "R10 msg vector", 64'(msg_vector), 64'(ev));
    chk(irq == (!msix_m && isr_m[0]), "R8 irq level", 64'(irq), 64'(!msix_m && isr_m[0]));
  endtask

  task automatic chk_irq();
    chk(irq == (!msix_m && isr_m[0]), "R8 irq", 64'(irq), 64'(!msix_m && isr_m[0]));
  endtask

  initial begin : watchdog
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    msix_m = 1'b0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!irq && !dev_reset && !notify && !msg_valid, "R6 reset state", {irq, dev_reset, notify, msg_valid}, 0);
    rd(18, "R6 status after reset");
    rd(19, "R7 isr after reset");
    rd(0, "R1 host features");
    // guest features, bad marker
    wr(4, 32'h0000_00F3); rd(4, "R2 guest feat");
    chk(guest_feat == 32'h0000_00F3, "R2 guest_feat_o", 64'(guest_feat), 64'h0F3);
    wr(4, 32'h4000_0001); rd(4, "R2 bad feature clears");
    // queue select
    wr(14, 2); rd(14, "R3 select");
    wr(14, 7); rd(14, "R3 out of range ignored");
    wr(14, 32'h0001_0001); rd(14, "R3 high bits out of range");
    // frame and size
    wr(8, 32'h0001_2345); rd(8, "R4 frame readback");
    chk(sel_qbase == 44'h0_1234_5000, "R4 base shift", 64'(sel_qbase), 64'h1234_5000);
    rd(12, "R4 queue size");
    wr(16, 3);
    // unmapped
    rd(1, "R12 unmapped"); rd(13, "R12 unmapped"); rd(16, "R12 notify reads ones");
    wr(2, 32'h55); wr(15, 32'h0);
    rd(4, "R12 no effect"); rd(14, "R12 no effect"); rd(8, "R12 no effect");
    // legacy interrupt
    evt(1'b1, 2); rd(19, "R7 isr queue"); chk_irq();
    evt(1'b0, 0); rd(19, "R7 isr config"); chk_irq();
    evt(1'b1, 1);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(19); evt_q = 1'b1;
    #1 chk(rdata == 32'(isr_m), "R7 read returns old", 64'(rdata), 64'(isr_m));
    isr_m = 8'h01;
    @(negedge clk);
    req = 1'b0; evt_q = 1'b0;
    chk_irq();
    rd(19, "R7 same-cycle event kept");
    // header forwarding with messages off
    wr(20, 32'hAB); rd(21, "R11 legacy header length");
    // device reset by status and by frame
    wr(18, 7); rd(18, "R6 status store");
    chk(status == 8'h07, "R6 status_o", 64'(status), 7);
    wr(14, 1); wr(8, 99); evt(1'b1, 0);
    wr(18, 32'h100);
    rd(8, "R6 frame cleared"); rd(14, "R6 select cleared"); rd(4, "R6 features cleared");
    rd(19, "R6 isr cleared");
    wr(8, 5); wr(4, 9); wr(8, 0);
    rd(8, "R6 frame-zero reset"); rd(4, "R6 frame-zero clears features");
    // message interrupts
    @(negedge clk); msix_en = 1'b1; msix_m = 1'b1;
    rd(20, "R9 config vector reset"); rd(22, "R9 queue vector reset");
    wr(20, 5); rd(20, "R9 config vector");
    wr(22, 9); rd(22, "R9 rejected vector");
    wr(22, 3); rd(22, "R9 accepted vector");
    evt(1'b1, 0); evt(1'b0, 0); evt(1'b1, 2);
    wr(20, 8); rd(20, "R9 vector count boundary"); evt(1'b0, 0);
    wr(24, 32'h77); rd(24, "R11 extended header");
    // random phases
    for (int ph = 0; ph < 2; ph++) begin
      for (int n = 0; n < 400; n++) begin
        int op;
        op = int'($urandom % 9);
        case (op)
          0: wr(14, $urandom % 6);
          1: wr(8, (($urandom % 16) == 0) ? 32'h0 : $urandom);
          2: wr(22, $urandom % 11);
          3: wr(20, $urandom % 11);
          4: wr(4, $urandom);
          5: wr(18, (($urandom % 16) == 0) ? 32'h0 : ($urandom % 256));
          6: evt(($urandom % 3) != 0, int'($urandom % NQ));
          7: rd(19, "R7 random isr");
          default: rd(int'($urandom % 28), "R12 random read");
        endcase
      end
      @(negedge clk); msix_en = 1'b0; msix_m = 1'b0;
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule